// File: doc/BRIEF.md
# Priority-Ordered Vector Sequencer

The sequencer accepts a set of eight byte-wide data lanes and an eight-bit priority mask, and sends the lanes out one per enabled clock until all eight have gone. The order comes from the mask in two passes. The first pass sends every lane whose mask bit is 1, from the highest lane number down. The second pass sends every lane whose mask bit is 0, again from the highest down. For example, mask 8'b11000101 gives the lane order 7, 6, 2, 0, 5, 4, 3, 1.

A sequence starts on the first enabled clock edge after reset or after the previous sequence has finished. On that edge the lane data and the mask are copied into the block. Later changes at the inputs have no effect until the eighth lane has been sent. The first lane of each sequence is taken straight from the live inputs on that edge. While enable is low the position in the sequence is frozen and no output is marked valid. When enable stays high, sequences follow one another with no gap.

Top module: `prio_vec_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, out_vec is 0 and out_valid and seq_done are low. The first enabled edge after reset starts a new sequence at its first slot, even if reset arrived in the middle of a sequence.
- R2: Every rising clock edge with en high produces exactly one output: out_valid is high and out_vec holds a lane value during the following cycle. Eight consecutive enabled edges deliver all eight lanes of a sequence.
- R3: Lane i is vec_in[8*i+7:8*i]. The first pass sends every lane i with prio_mask[i]=1, in descending order of i.
- R4: After the first pass, every lane with prio_mask[i]=0 is sent in descending order of i. With mask 8'b11000101 the lane order is 7, 6, 2, 0, 5, 4, 3, 1.
- R5: vec_in and prio_mask are sampled only on the first enabled edge of a sequence. Changes to them during the rest of the sequence change neither the values nor the order of the remaining outputs.
- R6: seq_done is high in exactly the cycle that carries the eighth lane of a sequence, and only when out_valid is high.
- R7: An edge with en low makes out_valid and seq_done low in the next cycle and leaves the sequence position unchanged. The next enabled edge sends the lane that would have come next.
- R8: A mask of all ones, or of all zeros, sends the lanes in the order 7, 6, 5, 4, 3, 2, 1, 0.
- R9: The enabled edge after a sequence's eighth lane starts a new sequence, sampling fresh inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance enable |
| vec_in | input | 64 | Eight data lanes, lane i in bits 8*i+7:8*i |
| prio_mask | input | 8 | Priority mask, bit i belongs to lane i |
| out_vec | output | 8 | Lane value sent in this cycle |
| out_valid | output | 1 | out_vec carries a lane |
| seq_done | output | 1 | This cycle carries the eighth lane of a sequence |

## Verification
The bench runs the example mask, sparse and dense masks, and the all-ones and all-zeros masks. A design that ran a single pass, or scanned upward, would send the lanes in the wrong order, so every slot is checked against the lane number the bench expects. Each lane holds a different value, so a wrong lane shows up as a wrong byte. The bench changes the data and the mask right after a sequence starts: a design that read the live inputs would emit the new bytes or reorder the tail. Stalls placed in the middle of a sequence catch a design that skips or repeats a slot while enable is low, and a reset in the middle of a sequence catches one that resumes at the old position instead of slot 0.

// File: rtl/prio_vec_seq.sv
module prio_vec_seq #(
  parameter int LANES = 8,
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [LANES*WIDTH-1:0]   vec_in,
  input  logic [LANES-1:0]         prio_mask,
  output logic [WIDTH-1:0]         out_vec,
  output logic                     out_valid,
  output logic                     seq_done
);
  localparam int IW = $clog2(LANES);
  localparam logic [IW-1:0] LAST = IW'(LANES - 1);

  logic [LANES*WIDTH-1:0] held_vec;
  logic [LANES-1:0]       held_mask;
  logic [IW-1:0]          pos;
  logic                   busy;

  logic [LANES*WIDTH-1:0] src_vec;
  logic [LANES-1:0]       src_mask;
  logic [IW-1:0]          sel;

  // slot k of the two-pass scan: set bits high-to-low, then clear bits high-to-low
  function automatic logic [IW-1:0] pick(input logic [LANES-1:0] m, input logic [IW-1:0] k);
    logic [IW:0]   n;
    logic [IW-1:0] r;
    n = '0;
    r = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (m[i]) begin
        if (n == {1'b0, k}) r = IW'(i);
        n = n + (IW+1)'(1);
      end
    end
    for (int i = LANES - 1; i >= 0; i--) begin
      if (!m[i]) begin
        if (n == {1'b0, k}) r = IW'(i);
        n = n + (IW+1)'(1);
      end
    end
    return r;
  endfunction

  assign src_vec  = busy ? held_vec  : vec_in;
  assign src_mask = busy ? held_mask : prio_mask;
  assign sel      = pick(src_mask, pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_vec  <= '0;
      held_mask <= '0;
      pos       <= '0;
      busy      <= 1'b0;
      out_vec   <= '0;
      out_valid <= 1'b0;
      seq_done  <= 1'b0;
    end else if (!en) begin
      out_valid <= 1'b0;
      seq_done  <= 1'b0;
    end else begin
      out_vec   <= src_vec[sel*WIDTH +: WIDTH];
      out_valid <= 1'b1;
      seq_done  <= (pos == LAST);
      if (!busy) begin
        held_vec  <= vec_in;
        held_mask <= prio_mask;
      end
      if (pos == LAST) begin
        pos  <= '0;
        busy <= 1'b0;
      end else begin
        pos  <= pos + IW'(1);
        busy <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/prio_vec_seq_chk.sv
module prio_vec_seq_chk #(
  parameter int LANES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic out_valid,
  input logic seq_done
);
  localparam int IW = $clog2(LANES);
  logic [IW-1:0] vcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vcnt <= '0;
    else if (out_valid) vcnt <= vcnt + IW'(1);
  end

  // R2
  enabled_edge_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> out_valid);

  // R7
  stall_gives_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!out_valid && !seq_done));

  // R6
  done_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> out_valid);

  // R6
  done_on_eighth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (seq_done == (vcnt == IW'(LANES - 1))));
endmodule

bind prio_vec_seq prio_vec_seq_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .out_valid(out_valid), .seq_done(seq_done)
);

// File: tb/prio_vec_seq_bench.sv
module prio_vec_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [63:0] vec_in = '0;
  logic [7:0]  prio_mask = '0;
  logic [7:0]  out_vec;
  logic        out_valid;
  logic        seq_done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  prio_vec_seq u_prio_vec_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .vec_in(vec_in), .prio_mask(prio_mask),
    .out_vec(out_vec), .out_valid(out_valid), .seq_done(seq_done)
  );

  function automatic int exp_lane(logic [7:0] m, int k);
    int n = 0;
    for (int key = 15; key >= 0; key--) begin
      if (m[key % 8] == 1'(key / 8)) begin
        if (n == k) return key % 8;
        n++;
      end
    end
    return 0;
  endfunction

  function automatic logic [63:0] make_data(logic [7:0] seed);
    logic [63:0] d;
    for (int i = 0; i < 8; i++) d[8*i +: 8] = seed ^ 8'(i * 37 + 11);
    return d;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // runs slots [from, to) of a sequence whose captured inputs are d/m
  task automatic run_slots(string req, logic [63:0] d, logic [7:0] m, int from, int to);
    for (int k = from; k < to; k++) begin
      en = 1'b1;
      tick();
      chk(req, "valid", 32'(out_valid), 32'd1);
      chk(req, "data", 32'(out_vec), 32'(d[8*exp_lane(m, k) +: 8]));
      chk("R6", "done", 32'(seq_done), 32'(k == 7));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    en = 1'b0;
    tick();
    chk("R1", "valid in reset", 32'(out_valid), 32'd0);
    chk("R1", "done in reset", 32'(seq_done), 32'd0);
    chk("R1", "data in reset", 32'(out_vec), 32'd0);
    rst_n = 1'b1;
    tick();
    chk("R1", "valid after reset", 32'(out_valid), 32'd0);
  endtask

  task automatic t_example();
    int order [8] = '{7, 6, 2, 0, 5, 4, 3, 1};
    logic [63:0] d = make_data(8'h5a);
    vec_in = d;
    prio_mask = 8'b11000101;
    for (int k = 0; k < 8; k++) begin
      en = 1'b1;
      tick();
      chk("R4", "example order", 32'(out_vec), 32'(d[8*order[k] +: 8]));
      chk("R3", "example valid", 32'(out_valid), 32'd1);
    end
    en = 1'b0;
  endtask

  task automatic t_uniform();
    logic [63:0] d = make_data(8'h33);
    vec_in = d;
    prio_mask = 8'hff;
    for (int k = 0; k < 8; k++) begin
      en = 1'b1;
      tick();
      chk("R8", "all ones", 32'(out_vec), 32'(d[8*(7-k) +: 8]));
    end
    d = make_data(8'hc4);
    vec_in = d;
    prio_mask = 8'h00;
    for (int k = 0; k < 8; k++) begin
      tick();
      chk("R8", "all zeros", 32'(out_vec), 32'(d[8*(7-k) +: 8]));
    end
    en = 1'b0;
  endtask

  task automatic t_masks();
    logic [7:0] masks [4] = '{8'b00010000, 8'b10000001, 8'b01111110, 8'b00101010};
    foreach (masks[j]) begin
      logic [63:0] d = make_data(8'(j * 19 + 1));
      vec_in = d;
      prio_mask = masks[j];
      run_slots("R3", d, masks[j], 0, 8);
    end
    en = 1'b0;
  endtask

  task automatic t_capture();
    logic [63:0] d = make_data(8'h91);
    logic [7:0]  m = 8'b01001011;
    vec_in = d;
    prio_mask = m;
    run_slots("R5", d, m, 0, 1);
    vec_in = make_data(8'h0f);
    prio_mask = ~m;
    run_slots("R5", d, m, 1, 8);
    d = make_data(8'h0f);
    run_slots("R9", d, ~m, 0, 8);
    en = 1'b0;
  endtask

  task automatic t_stall();
    logic [63:0] d = make_data(8'he7);
    logic [7:0]  m = 8'b10100110;
    vec_in = d;
    prio_mask = m;
    run_slots("R7", d, m, 0, 3);
    en = 1'b0;
    for (int s = 0; s < 3; s++) begin
      tick();
      chk("R7", "stall valid", 32'(out_valid), 32'd0);
      chk("R7", "stall done", 32'(seq_done), 32'd0);
    end
    run_slots("R7", d, m, 3, 7);
    en = 1'b0;
    tick();
    chk("R7", "stall before last", 32'(out_valid), 32'd0);
    run_slots("R7", d, m, 7, 8);
    en = 1'b0;
  endtask

  task automatic t_mid_reset();
    logic [63:0] d = make_data(8'h21);
    logic [7:0]  m = 8'b00110011;
    vec_in = d;
    prio_mask = m;
    run_slots("R1", d, m, 0, 4);
    do_reset();
    d = make_data(8'h77);
    m = 8'b11100000;
    vec_in = d;
    prio_mask = m;
    run_slots("R1", d, m, 0, 8);
    en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    do_reset();
    t_example();
    t_uniform();
    t_masks();
    t_capture();
    t_stall();
    t_mid_reset();
    tick();
    finish_run();
  end
endmodule